// File: doc/BRIEF.md
# Counted Block Move Engine

This block copies a run of elements from one memory region to another through a single shared memory port. Software, or a decoder in front of it, supplies a source pointer, a destination pointer, an element count and a variant code, then pulses `start`. The variant selects the element size, byte or word. It also selects which pointers step, and in which direction. In some variants one pointer stays fixed, as when a stream is drained into a device register or one location fills a table. A count of zero means the full count range.

Every element is one read handshake on the memory port followed by one write handshake. The working pointers and the count are visible at all times on `src_o`, `dst_o` and `cnt_o`. When an interrupt is pending at an element boundary, the block stops with the registers showing exactly the work that remains. Starting again from those values finishes the copy with no element lost or repeated. A word move with a misaligned pointer is refused with a bus-error pulse.

Top module: `blkmv_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `mem_req`, `done`, `suspend` and `bus_err` are low and `src_o`, `dst_o`, `cnt_o` are zero.
- R2: Variant code 0 (ascending words) reads a word at the source, writes it at the destination with all byte enables set, then adds 2 to both pointers.
- R3: Variant code 1 (descending words) moves words in the same way but subtracts 2 from both pointers, wrapping modulo the address width.
- R4: Variant codes 2 (word stream to fixed target) and 3 (byte stream to fixed target) advance the source by 2 or 1 and never change the destination.
- R5: Variant codes 4 (fixed origin to word table) and 5 (fixed origin to byte table) keep the source fixed and advance the destination by 2 or 1.
- R6: Bit i of `mem_be` enables data bits 8i+7 down to 8i, and the byte at address a lives in lane a[0]. A byte read is taken from lane src[0] with only that enable set. A byte write places the byte on both lanes with only enable dst[0] set.
- R7: Each element is exactly one read handshake followed by one write handshake. While `mem_req` is high and `mem_rdy` is low, `mem_req`, `mem_we` and `mem_addr` hold steady.
- R8: The count drops by one on each write handshake. When it reaches zero, `done` pulses for one cycle and `busy` falls. A start count of zero moves 2^CNT_W elements.
- R9: `irq_pend` is sampled on the write handshake. If it is high and the count is not zero, the block stops and pulses `suspend`, with the pointers and count showing the elements already moved. A new start from `src_o`, `dst_o`, `cnt_o` continues the sequence.
- R10: When the last element completes while `irq_pend` is high, `done` is pulsed and `suspend` is not.
- R11: A word variant started with either pointer odd makes no memory access. It pulses `bus_err` for one cycle, and `src_o`, `dst_o`, `cnt_o` keep their previous values.
- R12: A start with variant code 6 or 7 is ignored. `busy` stays low, no memory access is made, and the registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin or resume a move, sampled while idle |
| variant | input | 3 | Variant code 0 to 5 |
| src_in | input | ADDR_W (16) | Starting source pointer |
| dst_in | input | ADDR_W (16) | Starting destination pointer |
| cnt_in | input | CNT_W (16) | Element count, 0 means 2^CNT_W |
| irq_pend | input | 1 | Interrupt pending, sampled at each write handshake |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W (16) | Byte address of the access |
| mem_be | output | DATA_W/8 (2) | Byte-lane enables |
| mem_wdata | output | DATA_W (16) | Write data |
| mem_rdata | input | DATA_W (16) | Read data, valid with `mem_rdy` on a read |
| mem_rdy | input | 1 | Access completes in a cycle where `mem_req` and `mem_rdy` are both high |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle pulse, count reached zero |
| suspend | output | 1 | One-cycle pulse, stopped for an interrupt, restart required |
| bus_err | output | 1 | One-cycle pulse, misaligned word move refused |
| src_o | output | ADDR_W (16) | Current source pointer |
| dst_o | output | ADDR_W (16) | Current destination pointer |
| cnt_o | output | CNT_W (16) | Elements remaining |

## Verification
The hardest situation to reach is an interrupt that lands on an exact element boundary while the memory is stalling, followed by a restart from the exposed registers. The stimulus raises `irq_pend` right after a chosen number of write handshakes, under a pseudo-random ready pattern, so the stop falls after a known element. The bench restarts the move from `src_o`, `dst_o` and `cnt_o` and keeps comparing every access against one expected sequence computed for the whole move. A lost or repeated element shows up at once. A further case raises the interrupt on the final element to show that completion wins.

// File: rtl/blkmv_pkg.sv
// Shared definitions for the counted block move engine.
// Holds the variant codes, the sequencer states and a small helper.
package blkmv_pkg;

    // Variant codes; the code value is the external encoding on the variant port.
    typedef enum logic [2:0] {
        MV_WORD_UP     = 3'd0,
        MV_WORD_DN     = 3'd1,
        MV_WORD_TO_FIX = 3'd2,
        MV_BYTE_TO_FIX = 3'd3,
        MV_FIX_TO_WORD = 3'd4,
        MV_FIX_TO_BYTE = 3'd5
    } mv_kind_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } mv_state_e;

    // True for the variants that move single bytes.
    function automatic logic kind_is_byte(input logic [2:0] k);
        return (k == MV_BYTE_TO_FIX) || (k == MV_FIX_TO_BYTE);
    endfunction

endpackage

// File: rtl/blkmv_step.sv
// Variant decoder for the block move engine.
// Maps a variant code to its element size, its legality and the signed
// per-element steps of both pointers. Purely combinational.
// Assumes a word is LANES bytes wide and that steps wrap modulo 2^ADDR_W.
module blkmv_step
    import blkmv_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANES  = 2
) (
    input  logic [2:0]        kind,
    output logic              legal,
    output logic              byte_mode,
    output logic [ADDR_W-1:0] src_delta,
    output logic [ADDR_W-1:0] dst_delta
);

    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(LANES);
    localparam logic [ADDR_W-1:0] STEP_BACK = ADDR_W'(~STEP_WORD + 1'b1);
    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);

    // Decode the pointer steps for the selected variant.
    always_comb begin
        legal     = 1'b1;
        byte_mode = kind_is_byte(kind);
        src_delta = '0;
        dst_delta = '0;
        case (kind)
            MV_WORD_UP:     begin src_delta = STEP_WORD; dst_delta = STEP_WORD; end
            MV_WORD_DN:     begin src_delta = STEP_BACK; dst_delta = STEP_BACK; end
            MV_WORD_TO_FIX: begin src_delta = STEP_WORD; end
            MV_BYTE_TO_FIX: begin src_delta = STEP_BYTE; end
            MV_FIX_TO_WORD: begin dst_delta = STEP_WORD; end
            MV_FIX_TO_BYTE: begin dst_delta = STEP_BYTE; end
            default:        begin legal = 1'b0; end
        endcase
    end

endmodule

// File: rtl/blkmv_lanes.sv
// Byte-lane steering for the block move engine.
// On reads it extracts either the whole word or the byte in lane rd_lo.
// On writes it drives either the held word or the held byte copied onto
// every lane, and builds the byte enables.
// Assumes DATA_W is a multiple of 8 with at least two lanes.
module blkmv_lanes #(
    parameter int DATA_W    = 16,
    parameter int LANES     = DATA_W / 8,
    parameter int LANE_BITS = $clog2(LANES)
) (
    input  logic                 byte_mode,
    input  logic                 we,
    input  logic [LANE_BITS-1:0] rd_lo,
    input  logic [LANE_BITS-1:0] wr_lo,
    input  logic [DATA_W-1:0]    rdata,
    input  logic [DATA_W-1:0]    hold,
    output logic [DATA_W-1:0]    elem_rd,
    output logic [DATA_W-1:0]    wdata,
    output logic [LANES-1:0]     be
);

    logic [LANES-1:0]      rd_hit;
    logic [LANES-1:0]      wr_hit;
    logic [LANES-1:0][7:0] lane_pick;
    logic [7:0]            rd_byte;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rd_hit[i]        = (rd_lo == LANE_BITS'(i));
        assign wr_hit[i]        = (wr_lo == LANE_BITS'(i));
        assign lane_pick[i]     = rd_hit[i] ? rdata[8*i +: 8] : 8'h00;
        assign wdata[8*i +: 8]  = byte_mode ? hold[7:0] : hold[8*i +: 8];
        assign be[i]            = byte_mode ? (we ? wr_hit[i] : rd_hit[i]) : 1'b1;
    end

    // Merge the masked lanes into the selected read byte.
    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            rd_byte = rd_byte | lane_pick[i];
        end
    end

    // Present the element captured from a read: full word or zero-extended byte.
    always_comb begin
        elem_rd = byte_mode ? {{(DATA_W-8){1'b0}}, rd_byte} : rdata;
    end

endmodule

// File: rtl/blkmv_ctrl.sv
// Sequencer and working registers of the block move engine.
// Runs read, then write, for each element. It updates the pointers and the
// count on the write handshake and chooses done, suspend or the next element
// in that same cycle. Refuses misaligned word moves and illegal variants.
// Assumes the memory holds request fields stable only while it sees them.
module blkmv_ctrl
    import blkmv_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 16,
    parameter int LANE_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        kind_in,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              irq_pend,
    input  logic              legal,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] src_delta,
    input  logic [ADDR_W-1:0] dst_delta,
    input  logic [DATA_W-1:0] elem_rd,
    input  logic              mem_rdy,
    output logic [2:0]        kind_cur,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] hold,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              busy,
    output logic              done,
    output logic              suspend,
    output logic              bus_err
);

    mv_state_e   state;
    logic [2:0]  kind_q;
    logic        misaligned;
    logic        last_elem;

    // Variant seen by the decoder: the port while idle, the latched code while running.
    always_comb begin
        kind_cur = (state == ST_IDLE) ? kind_in : kind_q;
    end

    // Word moves need both starting pointers on a word boundary.
    always_comb begin
        misaligned = !byte_mode &&
                     ((src_in[LANE_BITS-1:0] != '0) || (dst_in[LANE_BITS-1:0] != '0));
        last_elem  = (cnt_q == CNT_W'(1));
    end

    // Memory request fields follow the state.
    always_comb begin
        mem_req  = (state == ST_READ) || (state == ST_WRITE);
        mem_we   = (state == ST_WRITE);
        mem_addr = (state == ST_WRITE) ? dst_q : src_q;
        busy     = (state != ST_IDLE);
    end

    // Sequencer, working registers and the one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            hold    <= '0;
            done    <= 1'b0;
            suspend <= 1'b0;
            bus_err <= 1'b0;
        end else begin
            done    <= 1'b0;
            suspend <= 1'b0;
            bus_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && legal) begin
                        if (misaligned) begin
                            bus_err <= 1'b1;
                        end else begin
                            kind_q <= kind_in;
                            src_q  <= src_in;
                            dst_q  <= dst_in;
                            cnt_q  <= cnt_in;
                            state  <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_rdy) begin
                        hold  <= elem_rd;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_rdy) begin
                        src_q <= src_q + src_delta;
                        dst_q <= dst_q + dst_delta;
                        cnt_q <= cnt_q - CNT_W'(1);
                        if (last_elem) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (irq_pend) begin
                            suspend <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R7
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_rdy) |=> (mem_req && mem_we));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == '0 && !busy));

    // R9
    susp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |-> ($past(irq_pend) && cnt_q != '0 && !busy));

    // R10
    susp_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(suspend && done));

    // R11
    berr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!mem_req && $stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

    // R12
    illegal_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !legal) |=> (!busy && !bus_err));

endmodule

// File: rtl/blkmv_engine.sv
// Counted block move engine, top level.
// Copies elements from a source pointer to a destination pointer through one
// shared memory port, counting down an element count, in one of six variants.
// It exposes the working registers so that an interrupt can stop the move
// and a later start can resume it. Assumes byte addresses with little-endian
// lanes: lane i carries the byte whose address has low bits equal to i.
module blkmv_engine #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2:0]            variant,
    input  logic [ADDR_W-1:0]     src_in,
    input  logic [ADDR_W-1:0]     dst_in,
    input  logic [CNT_W-1:0]      cnt_in,
    input  logic                  irq_pend,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic                  mem_rdy,
    output logic                  busy,
    output logic                  done,
    output logic                  suspend,
    output logic                  bus_err,
    output logic [ADDR_W-1:0]     src_o,
    output logic [ADDR_W-1:0]     dst_o,
    output logic [CNT_W-1:0]      cnt_o
);

    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    logic [2:0]        kind_cur;
    logic              legal;
    logic              byte_mode;
    logic [ADDR_W-1:0] src_delta;
    logic [ADDR_W-1:0] dst_delta;
    logic [DATA_W-1:0] elem_rd;
    logic [DATA_W-1:0] hold;

    blkmv_step #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) u_step (
        .kind      (kind_cur),
        .legal     (legal),
        .byte_mode (byte_mode),
        .src_delta (src_delta),
        .dst_delta (dst_delta)
    );

    blkmv_lanes #(
        .DATA_W    (DATA_W),
        .LANES     (LANES),
        .LANE_BITS (LANE_BITS)
    ) u_lanes (
        .byte_mode (byte_mode),
        .we        (mem_we),
        .rd_lo     (src_o[LANE_BITS-1:0]),
        .wr_lo     (dst_o[LANE_BITS-1:0]),
        .rdata     (mem_rdata),
        .hold      (hold),
        .elem_rd   (elem_rd),
        .wdata     (mem_wdata),
        .be        (mem_be)
    );

    blkmv_ctrl #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .DATA_W    (DATA_W),
        .LANE_BITS (LANE_BITS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind_in   (variant),
        .src_in    (src_in),
        .dst_in    (dst_in),
        .cnt_in    (cnt_in),
        .irq_pend  (irq_pend),
        .legal     (legal),
        .byte_mode (byte_mode),
        .src_delta (src_delta),
        .dst_delta (dst_delta),
        .elem_rd   (elem_rd),
        .mem_rdy   (mem_rdy),
        .kind_cur  (kind_cur),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .hold      (hold),
        .src_q     (src_o),
        .dst_q     (dst_o),
        .cnt_q     (cnt_o),
        .busy      (busy),
        .done      (done),
        .suspend   (suspend),
        .bus_err   (bus_err)
    );

endmodule

// File: tb/sim_blkmv_engine.sv
// Scoreboard bench for the block move engine. The driver pushes every
// expected memory access of a move into a queue. A monitor pops and
// compares each handshake as the design makes it.
module sim_blkmv_engine;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DW = 16;
    localparam int NL = DW / 8;

    logic          clk;
    logic          rst_n;
    logic          start;
    logic [2:0]    variant;
    logic [AW-1:0] src_in;
    logic [AW-1:0] dst_in;
    logic [CW-1:0] cnt_in;
    logic          irq_pend;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [NL-1:0] mem_be;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_rdy;
    logic          busy;
    logic          done;
    logic          suspend;
    logic          bus_err;
    logic [AW-1:0] src_o;
    logic [AW-1:0] dst_o;
    logic [CW-1:0] cnt_o;

    blkmv_engine #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .variant(variant),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .irq_pend(irq_pend),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .busy(busy), .done(done), .suspend(suspend), .bus_err(bus_err),
        .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o)
    );

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [NL-1:0] be;
    } xfer_t;

    xfer_t exp_q[$];
    int    n_checks;
    int    n_fail;
    string cur_tag;
    int    wr_seen;
    int    irq_at;
    bit    irq_arm;
    int    stall_mode;
    logic [7:0] lfsr;
    bit    finished;

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Memory image: word content is a function of the word address.
    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        logic [AW-1:0] w;
        w = {a[AW-1:1], 1'b0};
        return 16'(w * 16'd40503) ^ 16'h1D2B;
    endfunction

    function automatic logic [7:0] byte_at(input logic [AW-1:0] a);
        logic [DW-1:0] w;
        w = word_at(a);
        return a[0] ? w[15:8] : w[7:0];
    endfunction

    assign mem_rdata = word_at(mem_addr);

    function automatic bit is_byte(input int k);
        return (k == 3) || (k == 5);
    endfunction

    // Source step per variant, taken from the requirements.
    function automatic logic [AW-1:0] sstep(input int k);
        case (k)
            0: return 16'd2;
            1: return 16'hFFFE;
            2: return 16'd2;
            3: return 16'd1;
            default: return 16'd0;
        endcase
    endfunction

    // Destination step per variant, taken from the requirements.
    function automatic logic [AW-1:0] dstep(input int k);
        case (k)
            0: return 16'd2;
            1: return 16'hFFFE;
            4: return 16'd2;
            5: return 16'd1;
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Ready pattern: always ready, or stalls from a small LFSR.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (stall_mode)
            0: mem_rdy = 1'b1;
            1: mem_rdy = lfsr[0] | lfsr[2];
            default: mem_rdy = lfsr[1];
        endcase
    end

    // Monitor: compare each handshake with the front of the expected queue.
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_rdy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected access", {16'h0, mem_addr}, 32'h0);
            end else begin
                xfer_t e;
                e = exp_q.pop_front();
                check(mem_we == e.we, "R7 order", {31'h0, mem_we}, {31'h0, e.we});
                check(mem_addr == e.addr, {cur_tag, " addr"}, {16'h0, mem_addr}, {16'h0, e.addr});
                check(mem_be == e.be, {cur_tag, " be"}, {30'h0, mem_be}, {30'h0, e.be});
                if (e.we) begin
                    check(mem_wdata == e.data, {cur_tag, " data"}, {16'h0, mem_wdata}, {16'h0, e.data});
                end
            end
            if (mem_we) begin
                wr_seen++;
                irq_pend = irq_arm && (wr_seen >= irq_at);
            end
        end
    end

    // Driver side: push the expected access list of a whole move.
    task automatic push_move(input int k, input logic [AW-1:0] s, input logic [AW-1:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            xfer_t r;
            xfer_t w;
            logic [AW-1:0] sa;
            logic [AW-1:0] da;
            sa = 16'(s + 16'(i) * sstep(k));
            da = 16'(d + 16'(i) * dstep(k));
            r.we = 1'b0; r.addr = sa; r.data = '0;
            r.be = is_byte(k) ? (sa[0] ? 2'b10 : 2'b01) : 2'b11;
            w.we = 1'b1; w.addr = da;
            w.data = is_byte(k) ? {byte_at(sa), byte_at(sa)} : word_at(sa);
            w.be = is_byte(k) ? (da[0] ? 2'b10 : 2'b01) : 2'b11;
            exp_q.push_back(r);
            exp_q.push_back(w);
        end
    endtask

    task automatic pulse_start(input int k, input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [CW-1:0] c);
        variant = 3'(k); src_in = s; dst_in = d; cnt_in = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run a full move, resuming after any suspend from the exposed registers.
    task automatic run_move(input int k, input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input logic [CW-1:0] c, input int irq_after, input string tag);
        int n;
        bit fin;
        n = (c == 0) ? (1 << CW) : int'(c);
        cur_tag = tag;
        wr_seen = 0;
        irq_at  = irq_after;
        irq_arm = (irq_after > 0);
        irq_pend = 1'b0;
        push_move(k, s, d, n);
        pulse_start(k, s, d, c);
        fin = 0;
        while (!fin && !finished) begin
            while (!(done || suspend || bus_err) && !finished) @(negedge clk);
            if (finished) break;
            if (suspend) begin
                // R9: registers show exactly the elements already moved
                check(src_o == 16'(s + 16'(wr_seen) * sstep(k)), "R9 src after suspend", {16'h0, src_o}, {16'h0, 16'(s + 16'(wr_seen) * sstep(k))});
                check(dst_o == 16'(d + 16'(wr_seen) * dstep(k)), "R9 dst after suspend", {16'h0, dst_o}, {16'h0, 16'(d + 16'(wr_seen) * dstep(k))});
                check(cnt_o == CW'(int'(c) - wr_seen), "R9 cnt after suspend", {24'h0, cnt_o}, {24'h0, CW'(int'(c) - wr_seen)});
                check(!busy, "R9 idle after suspend", {31'h0, busy}, 32'h0);
                irq_arm = 0;
                irq_pend = 1'b0;
                pulse_start(k, src_o, dst_o, cnt_o);
            end else if (done) begin
                // R8 / R10: completion state
                check(suspend == 1'b0, "R10 no suspend with done", {31'h0, suspend}, 32'h0);
                check(cnt_o == '0, "R8 count zero", {24'h0, cnt_o}, 32'h0);
                check(src_o == 16'(s + 16'(n) * sstep(k)), {tag, " final src"}, {16'h0, src_o}, {16'h0, 16'(s + 16'(n) * sstep(k))});
                check(dst_o == 16'(d + 16'(n) * dstep(k)), {tag, " final dst"}, {16'h0, dst_o}, {16'h0, 16'(d + 16'(n) * dstep(k))});
                check(exp_q.size() == 0, "R8 all elements moved", exp_q.size(), 32'h0);
                check(wr_seen == n, "R8 element count", wr_seen, n);
                @(negedge clk);
                check(done == 1'b0, "R8 done is one cycle", {31'h0, done}, 32'h0);
                fin = 1;
            end else begin
                check(1'b0, {tag, " unexpected bus error"}, 32'h1, 32'h0);
                fin = 1;
            end
        end
        irq_arm = 0;
        irq_pend = 1'b0;
        exp_q.delete();
    endtask

    // Start a move that must be refused by a bus-error pulse (R11).
    task automatic run_misaligned(input int k, input logic [AW-1:0] s, input logic [AW-1:0] d);
        logic [AW-1:0] ps;
        logic [AW-1:0] pd;
        logic [CW-1:0] pc;
        ps = src_o; pd = dst_o; pc = cnt_o;
        cur_tag = "R11";
        pulse_start(k, s, d, 8'd3);
        check(bus_err == 1'b1, "R11 bus error pulse", {31'h0, bus_err}, 32'h1);
        check(busy == 1'b0 && mem_req == 1'b0, "R11 no access", {30'h0, busy, mem_req}, 32'h0);
        @(negedge clk);
        check(bus_err == 1'b0, "R11 pulse ends", {31'h0, bus_err}, 32'h0);
        check(src_o == ps && dst_o == pd && cnt_o == pc, "R11 registers kept", {16'h0, src_o}, {16'h0, ps});
    endtask

    // Start with an undefined variant code, which must be ignored (R12).
    task automatic run_illegal(input int k);
        logic [AW-1:0] ps;
        logic [CW-1:0] pc;
        bit seen;
        ps = src_o; pc = cnt_o;
        cur_tag = "R12";
        seen = 0;
        pulse_start(k, 16'h0040, 16'h0080, 8'd2);
        for (int i = 0; i < 4; i++) begin
            if (busy || mem_req || bus_err) seen = 1;
            @(negedge clk);
        end
        check(!seen, "R12 illegal variant ignored", {31'h0, seen}, 32'h0);
        check(src_o == ps && cnt_o == pc, "R12 registers kept", {16'h0, src_o}, {16'h0, ps});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        n_checks = 0; n_fail = 0; finished = 0;
        wr_seen = 0; irq_at = 0; irq_arm = 0; irq_pend = 1'b0;
        stall_mode = 0; lfsr = 8'hA7; mem_rdy = 1'b1;
        start = 1'b0; variant = '0; src_in = '0; dst_in = '0; cnt_in = '0;
        cur_tag = "R1";
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !mem_req && !done && !suspend && !bus_err, "R1 outputs idle",
              {27'h0, busy, mem_req, done, suspend, bus_err}, 32'h0);
        check(src_o == '0 && dst_o == '0 && cnt_o == '0, "R1 registers zero", {16'h0, src_o}, 32'h0);

        run_move(0, 16'h0100, 16'h0400, 8'd5, 0, "R2");
        stall_mode = 1;
        run_move(0, 16'h3000, 16'h3100, 8'd4, 0, "R2");
        run_move(1, 16'h0820, 16'h0A40, 8'd4, 0, "R3");
        run_move(1, 16'h0002, 16'h0004, 8'd3, 0, "R3");
        run_move(2, 16'h0200, 16'h7FFE, 8'd3, 0, "R4");
        run_move(3, 16'h0301, 16'h0555, 8'd6, 0, "R4");
        run_move(4, 16'h1234, 16'h2000, 8'd4, 0, "R5");
        run_move(5, 16'h0777, 16'h0900, 8'd5, 0, "R5");
        stall_mode = 2;
        run_move(3, 16'h0410, 16'h0601, 8'd4, 0, "R6");
        run_move(5, 16'h0A0B, 16'h0C0C, 8'd3, 0, "R6");
        stall_mode = 0;
        run_move(0, 16'h4000, 16'h5000, 8'd0, 0, "R8");
        stall_mode = 1;
        run_move(0, 16'h0600, 16'h0700, 8'd10, 3, "R9");
        run_move(3, 16'h0111, 16'h0222, 8'd7, 2, "R9");
        stall_mode = 2;
        run_move(1, 16'h0900, 16'h0B00, 8'd4, 4, "R10");
        stall_mode = 0;
        run_misaligned(0, 16'h1001, 16'h2000);
        run_misaligned(2, 16'h1000, 16'h2003);
        run_illegal(6);
        run_illegal(7);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule